// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is a 16-tap FIR filter with fixed coefficients and no multipliers. A new two's-complement sample enters a delay line when the source offers it and the filter is idle. The filter then spends one clock on each bit position of the samples. In each of those clocks, the bits at that position across all sixteen stored samples form an address. The address is split into four 4-bit groups, and each group reads a small table of precomputed coefficient sums. The four partial sums are combined in a registered adder tree. The result is scaled by the power of two for that bit position and added into a wide accumulator. The sign-bit contribution is subtracted.

When the last bit position has been accumulated, the accumulator is truncated by dropping its ten low-order bits. The result is presented on the output with a one-cycle valid pulse. The coefficients are parameters that are folded into the tables at elaboration. When the coefficient set is mirror-symmetric, each upper tap group reads the table of its mirror group through a bit-reversed address.

Top module: `da_fir16`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0, `out_sample` is 0, `in_ready` is 1, and every stored sample is zero.
- R2: A sample is taken at a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 for exactly 12 cycles and returns to 1 in the 13th.
- R3: A value offered on `in_sample` while `in_ready` is 0 is ignored. It never enters the delay line and never affects any output.
- R4: Each accepted sample produces exactly one `out_valid` pulse, one cycle long. The pulse is visible after the 15th rising edge that follows the accepting edge.
- R5: The output is y = sum over k of c[k]·x[n-k], where x[n] is the newest sample and c[k] is coefficient k. The result is shifted right arithmetically by 10 bits (rounding toward minus infinity). Samples older than reset count as zero.
- R6: Bit 11 of each sample carries weight −2048. The most negative input −2048 is therefore handled exactly.
- R7: The delay line keeps the 16 most recent accepted samples. A sample leaves the sum after 16 newer samples have been accepted.
- R8: Between pulses, `out_sample` holds the value of the most recent pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source offers `in_sample` |
| in_sample | input | 12 | Signed input sample |
| in_ready | output | 1 | Filter is idle and will take a sample |
| out_valid | output | 1 | One-cycle pulse: `out_sample` is new |
| out_sample | output | 19 | Signed, truncated filter output |

## Verification
Assertions check the following on every cycle:
- the delay line shifts only on acceptance and holds otherwise;
- the filter reports busy right after it takes a sample;
- the bit counter stays in range;
- bit positions reach the accumulator in unbroken ascending order;
- output pulses last one cycle, and the output word changes only together with a pulse.

The arithmetic cannot be proved from those local facts. These behaviours come only from the bench's scenarios, compared cycle by cycle against a direct convolution model:
- the exact filtered values, including the negatively weighted sign bit and the −2048 extreme;
- the 15-cycle latency;
- the 13-cycle acceptance period;
- the impulse response falling away after 16 samples;
- ignored input during busy cycles.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

  // Per-cycle bit-slice tag that travels alongside the data through the pipeline
  typedef struct packed {
    logic       valid;
    logic       first;
    logic       last;
    logic [4:0] bitpos;
  } da_tag_t;

  // Scale a partial sum by 2^b; the sign-bit slice is subtracted
  function automatic longint weigh(input longint part, input int b, input bit neg);
    longint s;
    s = part <<< b;
    return neg ? -s : s;
  endfunction

endpackage

// File: rtl/da_tap_line.sv
module da_tap_line #(
  parameter int TAPS = 16,
  parameter int IN_W = 12,
  localparam int BW  = $clog2(IN_W)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   shift_en,
  input  logic signed [IN_W-1:0] sample_in,
  input  logic [BW-1:0]          bit_sel,
  output logic [TAPS-1:0]        slice
);

  logic signed [IN_W-1:0] taps [TAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) taps[k] <= '0;
    end else if (shift_en) begin
      taps[0] <= sample_in;
      for (int k = 1; k < TAPS; k++) taps[k] <= taps[k-1];
    end
  end

  always_comb begin
    for (int k = 0; k < TAPS; k++) slice[k] = taps[k][bit_sel];
  end

  // R7: an accepted sample pushes the newest stored sample one place down
  a_r7_shift: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> taps[1] == $past(taps[0]));

  // R3: without acceptance the newest stored sample is untouched
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> taps[0] == $past(taps[0]));

endmodule

// File: rtl/da_group_rom.sv
module da_group_rom #(
  parameter int GW     = 4,
  parameter int COEF_W = 12,
  parameter int PS_W   = 17,
  parameter logic signed [GW-1:0][COEF_W-1:0] GCOEF = '0,
  parameter bit MIRROR = 1'b0
) (
  input  logic [GW-1:0]          addr,
  output logic signed [PS_W-1:0] psum
);

  localparam int DEPTH = 2 ** GW;

  logic signed [PS_W-1:0] rom [DEPTH];
  logic [GW-1:0]          idx;

  // Entry e = sum of the group's coefficients whose bit is set in e
  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      rom[e] = '0;
      for (int i = 0; i < GW; i++)
        if (e[i]) rom[e] = rom[e] + PS_W'(signed'(GCOEF[i]));
    end
  end

  // A mirrored group reads its partner's table with the address reversed
  always_comb begin
    for (int i = 0; i < GW; i++) idx[i] = MIRROR ? addr[GW-1-i] : addr[i];
  end

  assign psum = rom[idx];

endmodule

// File: rtl/da_adder_tree.sv
module da_adder_tree
  import da_fir_pkg::*;
#(
  parameter int LEAVES = 4,
  parameter int W      = 17
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] leaf [LEAVES],
  input  da_tag_t             tag_in,
  output logic signed [W-1:0] total,
  output da_tag_t             tag_out
);

  localparam int LV = $clog2(LEAVES);

  for (genvar l = 0; l <= LV; l++) begin : lvl
    localparam int N = LEAVES >> l;
    logic signed [W-1:0] s [N];
    da_tag_t             t;
    if (l == 0) begin : g_leaf
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < N; i++) s[i] <= '0;
          t <= '0;
        end else begin
          for (int i = 0; i < N; i++) s[i] <= leaf[i];
          t <= tag_in;
        end
      end
    end else begin : g_add
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < N; i++) s[i] <= '0;
          t <= '0;
        end else begin
          for (int i = 0; i < N; i++) s[i] <= lvl[l-1].s[2*i] + lvl[l-1].s[2*i+1];
          t <= lvl[l-1].t;
        end
      end
    end
  end

  assign total   = lvl[LV].s[0];
  assign tag_out = lvl[LV].t;

endmodule

// File: rtl/da_accum.sv
module da_accum
  import da_fir_pkg::*;
#(
  parameter int W     = 17,
  parameter int ACC_W = 29,
  parameter int IN_W  = 12,
  parameter int DROP  = 10,
  localparam int OW   = ACC_W - DROP
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [W-1:0]  total,
  input  da_tag_t              tag,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_sample
);

  logic signed [ACC_W-1:0] acc, term, acc_next;

  always_comb begin
    term     = ACC_W'(weigh(longint'(total), int'(tag.bitpos), tag.bitpos == 5'(IN_W-1)));
    acc_next = tag.first ? term : acc + term;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= tag.valid && tag.last;
      if (tag.valid) acc <= acc_next;
      if (tag.valid && tag.last) out_sample <= OW'(acc_next >>> DROP);
    end
  end

  // R4: bit slices arrive in unbroken ascending order within a sample
  a_r4_bit_order: assert property (@(posedge clk) disable iff (rst)
    (tag.valid && !tag.first) |-> ($past(tag.valid) && ($past(tag.bitpos) + 5'd1 == tag.bitpos)));

  // R4: output pulse lasts a single cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R8: output word only changes together with a pulse
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_sample));

endmodule

// File: rtl/da_fir16.sv
module da_fir16
  import da_fir_pkg::*;
#(
  parameter int TAPS      = 16,
  parameter int IN_W      = 12,
  parameter int COEF_W    = 12,
  parameter int GW        = 4,
  parameter int DROP      = 10,
  parameter bit SYMMETRIC = 1'b1,
  parameter logic signed [TAPS-1:0][COEF_W-1:0] COEFS = {
    -12'sd12, -12'sd31, 12'sd18, 12'sd95, 12'sd44, -12'sd210, 12'sd390, 12'sd1500,
    12'sd1500, 12'sd390, -12'sd210, 12'sd44, 12'sd95, 12'sd18, -12'sd31, -12'sd12},
  localparam int ACC_W    = COEF_W + IN_W + $clog2(TAPS) + 1,
  localparam int OUT_W    = ACC_W - DROP
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_sample,
  output logic                    in_ready,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_sample
);

  localparam int NG   = TAPS / GW;
  localparam int BW   = $clog2(IN_W);
  localparam int PS_W = COEF_W + $clog2(TAPS) + 1;

  logic          busy;
  logic [BW-1:0] bit_cnt;
  logic          accept;
  logic [TAPS-1:0] slice;
  da_tag_t       tag_issue, tag_sum;
  logic signed [PS_W-1:0] leaf [NG];
  logic signed [PS_W-1:0] total;

  assign in_ready = !busy;
  assign accept   = in_valid && !busy;

  // Bit-serial sequencer: one bit position per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      bit_cnt <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      bit_cnt <= '0;
    end else if (busy) begin
      if (bit_cnt == BW'(IN_W-1)) begin
        busy    <= 1'b0;
        bit_cnt <= '0;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    tag_issue.valid  = busy;
    tag_issue.first  = (bit_cnt == '0);
    tag_issue.last   = (bit_cnt == BW'(IN_W-1));
    tag_issue.bitpos = 5'(bit_cnt);
  end

  da_tap_line #(.TAPS(TAPS), .IN_W(IN_W)) u_taps (
    .clk(clk), .rst(rst), .shift_en(accept), .sample_in(in_sample),
    .bit_sel(bit_cnt), .slice(slice)
  );

  for (genvar g = 0; g < NG; g++) begin : grp
    localparam bit SHARE = SYMMETRIC && (g >= NG / 2);
    localparam int SRC   = SHARE ? (NG - 1 - g) : g;
    da_group_rom #(
      .GW(GW), .COEF_W(COEF_W), .PS_W(PS_W),
      .GCOEF(COEFS[SRC*GW +: GW]), .MIRROR(SHARE)
    ) u_rom (
      .addr(slice[g*GW +: GW]), .psum(leaf[g])
    );
  end

  da_adder_tree #(.LEAVES(NG), .W(PS_W)) u_tree (
    .clk(clk), .rst(rst), .leaf(leaf), .tag_in(tag_issue),
    .total(total), .tag_out(tag_sum)
  );

  da_accum #(.W(PS_W), .ACC_W(ACC_W), .IN_W(IN_W), .DROP(DROP)) u_acc (
    .clk(clk), .rst(rst), .total(total), .tag(tag_sum),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  // R2: taking a sample makes the filter busy on the next cycle
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready);

  // R2: bit counter never leaves the sample's bit range
  a_r2_bitcnt_range: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= BW'(IN_W-1));

endmodule

// File: tb/sim_da_fir16.sv
module sim_da_fir16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [11:0] in_sample = '0;
  logic in_ready, out_valid;
  logic signed [18:0] out_sample;

  always #5 clk = ~clk;

  da_fir16 u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .in_ready(in_ready), .out_valid(out_valid), .out_sample(out_sample)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int busy_left = 0;
  int held   = 0;
  bit ignored_seen = 0;
  int hist [16];
  int coef [16] = '{-12, -31, 18, 95, 44, -210, 390, 1500,
                    1500, 390, -210, 44, 95, 18, -31, -12};
  int    exp_val [$];
  int    exp_due [$];
  string exp_tag [$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Behavioural reference, compared every cycle
  always @(negedge clk) begin
    if (!rst) begin
      bit ev;
      cyc++;
      if (busy_left > 0) busy_left--;
      chk(in_ready == (busy_left == 0), "R2 in_ready", int'(in_ready), int'(busy_left == 0));
      ev = (exp_due.size() > 0) && (exp_due[0] == cyc);
      chk(out_valid == ev, "R4 out_valid timing", int'(out_valid), int'(ev));
      if (ev) begin
        chk(int'(out_sample) == exp_val[0], exp_tag[0], int'(out_sample), exp_val[0]);
        held = exp_val[0];
        void'(exp_val.pop_front());
        void'(exp_due.pop_front());
        void'(exp_tag.pop_front());
      end else begin
        chk(int'(out_sample) == held, "R8 hold", int'(out_sample), held);
      end
      if (in_valid && busy_left != 0) ignored_seen = 1;
      if (in_valid && busy_left == 0) begin
        int y;
        bit has_min, all_zero;
        for (int k = 15; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = int'(in_sample);
        y = 0; has_min = 0; all_zero = 1;
        for (int k = 0; k < 16; k++) begin
          y += coef[k] * hist[k];
          if (hist[k] == -2048) has_min = 1;
          if (hist[k] != 0) all_zero = 0;
        end
        exp_val.push_back(y >>> 10);
        exp_due.push_back(cyc + 16);
        exp_tag.push_back(has_min ? "R6 sign-bit value" :
                          ignored_seen ? "R3 ignored-input value" :
                          all_zero ? "R7 tail value" : "R5 value");
        ignored_seen = 0;
        busy_left = 13;
      end
    end
  end

  // Offer one sample; in noisy mode the data changes every waiting cycle
  task automatic send(input int x, input bit noisy);
    bit ok;
    @(posedge clk); #2;
    in_valid  = 1'b1;
    in_sample = 12'(x);
    do begin
      @(negedge clk);
      ok = in_ready;
      @(posedge clk); #2;
      if (!ok && noisy) in_sample = 12'($urandom_range(0, 4095));
    end while (!ok);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic run_all();
    for (int k = 0; k < 16; k++) hist[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(out_sample == '0, "R1 out_sample", int'(out_sample), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    @(posedge clk); #2 rst = 1'b0;
    // Impulse; R7 tail goes to zero after 16 zeros
    send(1000, 0);
    for (int i = 0; i < 18; i++) send(0, 0);
    // Most negative impulse (R6)
    send(-2048, 0);
    for (int i = 0; i < 18; i++) send(0, 0);
    // Steps
    for (int i = 0; i < 20; i++) send(2047, 0);
    for (int i = 0; i < 20; i++) send(-2048, 0);
    for (int i = 0; i < 18; i++) send(0, 0);
    // Random with gaps
    for (int i = 0; i < 120; i++) begin
      send(int'($urandom_range(0, 4095)) - 2048, 0);
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 20));
    end
    // Input held valid and changing while busy (R3)
    for (int i = 0; i < 40; i++) send(int'($urandom_range(0, 4095)) - 2048, 1);
    idle(40);
    chk(exp_due.size() == 0, "R4 all outputs seen", exp_due.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog actual=%0d expected=%0d", 100000, 0);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule